// File: doc/BRIEF.md
# 16-bit Carry Arithmetic Unit

This unit carries out the 16-bit add-with-carry and subtract-with-carry step of an 8-bit processor's register-pair datapath. The destination pair is the accumulator pair. The second operand is one of four register pairs, and the accumulator pair itself is one of them. A single opcode byte selects the operation and the operand. The unit returns three values: the new accumulator pair, a full eight-bit flag byte, and the hidden address-pointer value that the processor keeps for later instructions.

The issuing stage presents the four candidate pairs, the current carry flag and the opcode, then raises `strobe` for one cycle. Exactly one clock later the result, flags, pointer and cycle cost are registered and `res_valid` pulses high. The outputs then stay unchanged until the next strobe, so the writeback stage can take them at any later cycle. The unit does not fetch operands and writes back only the accumulator pair.

Top module: `carry_arith16`

## Requirements
- R1: With opcode bit 3 set (add), `acc_out` equals `acc_in` + operand + `carry_in`, modulo 2^16.
- R2: With opcode bit 3 clear (subtract), `acc_out` equals `acc_in` − operand − `carry_in`, modulo 2^16.
- R3: Opcode bits 5:4 select the operand: 00 picks `pair0_in`, 01 picks `pair1_in`, 10 picks `acc_in` itself, and 11 picks `stack_in`. For the self case, both inputs use the value before the operation.
- R4: Flag bit 7 (sign) equals result bit 15. Flag bit 6 (zero) is set exactly when the 16-bit result is zero.
- R5: Flag bit 1 (negate) is 0 for add and 1 for subtract. Flag bit 0 (carry) is the carry out of bit 15 for add and the borrow out of bit 15 for subtract.
- R6: Flag bit 4 (half) is the carry out of bit 11 for add and the borrow out of bit 11 for subtract. Flag bit 3 copies result bit 11 and flag bit 5 copies result bit 13.
- R7: Flag bit 2 (overflow) is set on add when both operands share a sign and the result's sign differs from it. On subtract it is set when the operand signs differ and the result's sign differs from `acc_in`.
- R8: `ptr_out` equals the pre-operation `acc_in` + 1, wrapping from FFFF to 0000.
- R9: `res_valid` is a one-cycle pulse in the cycle after each `strobe`. `acc_out`, `flags_out`, `ptr_out` and `tstates_out` do not change in any cycle that does not follow a strobe, whatever the inputs do.
- R10: After any strobe, `tstates_out` reports 15 for every operand and mode.
- R11: During and after reset, before any strobe, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Starts an operation on the current inputs |
| opcode | input | 8 | Opcode byte; bits 5:4 select the operand, bit 3 selects add |
| acc_in | input | 16 | Accumulator pair before the operation |
| pair0_in | input | 16 | Operand candidate 0 |
| pair1_in | input | 16 | Operand candidate 1 |
| stack_in | input | 16 | Operand candidate 3 (stack pointer) |
| carry_in | input | 1 | Incoming carry flag |
| res_valid | output | 1 | One-cycle pulse when a new result is registered |
| acc_out | output | 16 | New accumulator pair |
| flags_out | output | 8 | Flags: S7 Z6 Y5 H4 X3 V2 N1 C0 |
| ptr_out | output | 16 | Hidden pointer value (old accumulator + 1) |
| tstates_out | output | 5 | Cycle cost of the instruction |

## Verification
Two pairs of behaviours coincide in a single result. In the first, an incoming carry ripples across the whole word, so the half flag, the full carry and the zero flag all change together. The bench provokes this with FFFF + 0000 + 1 and with 0000 − 0000 − 1, and checks each flag bit against its own bench-computed expectation. In the second, one strobe follows the previous result's capture directly. The bench issues back-to-back strobes with changed operands and confirms that the second result replaces the first only in the cycle after its own strobe. It also confirms that operand changes without a strobe leave every output unchanged.

// File: rtl/carry_arith16_pkg.sv
package carry_arith16_pkg;

  typedef enum logic [1:0] {
    SRC_PAIR0 = 2'b00,
    SRC_PAIR1 = 2'b01,
    SRC_SELF  = 2'b10,
    SRC_STACK = 2'b11
  } src_sel_e;

  // flag byte, most significant field first
  typedef struct packed {
    logic sign;
    logic zero;
    logic copy_hi;
    logic half;
    logic copy_lo;
    logic ovf;
    logic neg;
    logic carry;
  } flag_byte_t;

  localparam int unsigned SEL_LSB  = 4;
  localparam int unsigned MODE_BIT = 3;

endpackage

// File: rtl/carry_arith16_decode.sv
module carry_arith16_decode
  import carry_arith16_pkg::*;
#(
  parameter int unsigned OPW = 8
) (
  input  logic [OPW-1:0] opcode,
  output src_sel_e       src_sel,
  output logic           is_sub
);
  always_comb begin
    src_sel = src_sel_e'(opcode[SEL_LSB +: 2]);
    is_sub  = ~opcode[MODE_BIT];
  end
endmodule

// File: rtl/carry_arith16_opmux.sv
module carry_arith16_opmux
  import carry_arith16_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  src_sel_e        src_sel,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   pair0_in,
  input  logic [DW-1:0]   pair1_in,
  input  logic [DW-1:0]   stack_in,
  output logic [DW-1:0]   operand
);
  always_comb begin
    unique case (src_sel)
      SRC_PAIR0: operand = pair0_in;
      SRC_PAIR1: operand = pair1_in;
      SRC_SELF:  operand = acc_in;   // pre-operation value on both inputs
      default:   operand = stack_in;
    endcase
  end
endmodule

// File: rtl/carry_arith16_core.sv
module carry_arith16_core
  import carry_arith16_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          is_sub,
  output logic [DW-1:0] result,
  output flag_byte_t    flags,
  output logic [DW-1:0] ptr,
  output logic          chain_carry,
  output logic          chain_half
);
  localparam int unsigned LW = DW - 4;   // low segment ends at bit 11
  localparam int unsigned XB = DW - 5;   // result bit copied to flag bit 3
  localparam int unsigned YB = DW - 3;   // result bit copied to flag bit 5

  function automatic logic [DW:0] f_wide_sum(input logic [DW-1:0] x,
                                             input logic [DW-1:0] y,
                                             input logic          c);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, c};
  endfunction

  function automatic logic [LW:0] f_low_sum(input logic [LW-1:0] x,
                                            input logic [LW-1:0] y,
                                            input logic          c);
    return {1'b0, x} + {1'b0, y} + {{LW{1'b0}}, c};
  endfunction

  function automatic logic f_overflow(input logic sa, input logic sb,
                                      input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [DW:0]   wide;
  logic [LW:0]   low;

  always_comb begin
    // subtract as a + ~b + ~c; carry outs invert into borrows
    b_eff       = is_sub ? ~b : b;
    c_eff       = is_sub ? ~cin : cin;
    wide        = f_wide_sum(a, b_eff, c_eff);
    low         = f_low_sum(a[LW-1:0], b_eff[LW-1:0], c_eff);
    result      = wide[DW-1:0];
    chain_carry = wide[DW] ^ is_sub;
    chain_half  = low[LW] ^ is_sub;

    flags.sign    = result[DW-1];
    flags.zero    = (result == '0);
    flags.copy_hi = result[YB];
    flags.half    = chain_half;
    flags.copy_lo = result[XB];
    flags.ovf     = f_overflow(a[DW-1], b_eff[DW-1], result[DW-1]);
    flags.neg     = is_sub;
    flags.carry   = chain_carry;

    ptr = a + {{(DW-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/carry_arith16_outreg.sv
module carry_arith16_outreg
  import carry_arith16_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned CW  = 5,
  parameter int unsigned CYC = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] result,
  input  flag_byte_t    flags,
  input  logic [DW-1:0] ptr,
  output logic          valid_q,
  output logic [DW-1:0] result_q,
  output flag_byte_t    flags_q,
  output logic [DW-1:0] ptr_q,
  output logic [CW-1:0] cyc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
      ptr_q    <= '0;
      cyc_q    <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        result_q <= result;
        flags_q  <= flags;
        ptr_q    <= ptr;
        cyc_q    <= CW'(CYC);
      end
    end
  end
endmodule

// File: rtl/carry_arith16.sv
module carry_arith16
  import carry_arith16_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned OPW = 8,
  parameter int unsigned CW  = 5,
  parameter int unsigned CYC = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe,
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0]  acc_in,
  input  logic [DW-1:0]  pair0_in,
  input  logic [DW-1:0]  pair1_in,
  input  logic [DW-1:0]  stack_in,
  input  logic           carry_in,
  output logic           res_valid,
  output logic [DW-1:0]  acc_out,
  output logic [7:0]     flags_out,
  output logic [DW-1:0]  ptr_out,
  output logic [CW-1:0]  tstates_out
);
  src_sel_e      src_sel;
  logic          is_sub;
  logic [DW-1:0] operand;
  logic [DW-1:0] sum_w;
  flag_byte_t    flags_w;
  logic [DW-1:0] ptr_w;
  logic          chain_carry;
  logic          chain_half;
  flag_byte_t    flags_q;

  carry_arith16_decode #(.OPW(OPW)) u_decode (
    .opcode (opcode),
    .src_sel(src_sel),
    .is_sub (is_sub)
  );

  carry_arith16_opmux #(.DW(DW)) u_opmux (
    .src_sel (src_sel),
    .acc_in  (acc_in),
    .pair0_in(pair0_in),
    .pair1_in(pair1_in),
    .stack_in(stack_in),
    .operand (operand)
  );

  carry_arith16_core #(.DW(DW)) u_core (
    .a          (acc_in),
    .b          (operand),
    .cin        (carry_in),
    .is_sub     (is_sub),
    .result     (sum_w),
    .flags      (flags_w),
    .ptr        (ptr_w),
    .chain_carry(chain_carry),
    .chain_half (chain_half)
  );

  carry_arith16_outreg #(.DW(DW), .CW(CW), .CYC(CYC)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (strobe),
    .result  (sum_w),
    .flags   (flags_w),
    .ptr     (ptr_w),
    .valid_q (res_valid),
    .result_q(acc_out),
    .flags_q (flags_q),
    .ptr_q   (ptr_out),
    .cyc_q   (tstates_out)
  );

  assign flags_out = flags_q;
endmodule

// File: rtl/carry_arith16_chk.sv
module carry_arith16_chk #(
  parameter int unsigned DW  = 16,
  parameter int unsigned OPW = 8,
  parameter int unsigned CW  = 5,
  parameter int unsigned CYC = 15
) (
  input logic           clk,
  input logic           rst_n,
  input logic           strobe,
  input logic [OPW-1:0] opcode,
  input logic [DW-1:0]  acc_in,
  input logic           res_valid,
  input logic [DW-1:0]  acc_out,
  input logic [7:0]     flags_out,
  input logic [DW-1:0]  ptr_out,
  input logic [CW-1:0]  tstates_out
);
  p_pulse_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> res_valid);

  p_no_pulse_without_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !res_valid);

  p_outputs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(acc_out) && $stable(flags_out) && $stable(ptr_out)
                 && $stable(tstates_out)));

  p_ptr_is_acc_plus_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> ((ptr_out - $past(acc_in)) == DW'(1)));

  p_neg_flag_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (flags_out[1] == !$past(opcode[3])));

  p_sign_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((flags_out[7] == acc_out[DW-1]) && (flags_out[6] == (acc_out == '0))));

  p_copy_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((flags_out[3] == acc_out[DW-5]) && (flags_out[5] == acc_out[DW-3])));

  p_cycle_cost_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (tstates_out == CW'(CYC)));
endmodule

bind carry_arith16 carry_arith16_chk #(.DW(DW), .OPW(OPW), .CW(CW), .CYC(CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe     (strobe),
  .opcode     (opcode),
  .acc_in     (acc_in),
  .res_valid  (res_valid),
  .acc_out    (acc_out),
  .flags_out  (flags_out),
  .ptr_out    (ptr_out),
  .tstates_out(tstates_out)
);

// File: tb/carry_arith16_bench.sv
module carry_arith16_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] acc_in = 16'h0, pair0_in = 16'h0, pair1_in = 16'h0, stack_in = 16'h0;
  logic        carry_in = 1'b0;
  logic        res_valid;
  logic [15:0] acc_out, ptr_out;
  logic [7:0]  flags_out;
  logic [4:0]  tstates_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_arith16 u_carry_arith16 (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opcode(opcode),
    .acc_in(acc_in), .pair0_in(pair0_in), .pair1_in(pair1_in),
    .stack_in(stack_in), .carry_in(carry_in), .res_valid(res_valid),
    .acc_out(acc_out), .flags_out(flags_out), .ptr_out(ptr_out),
    .tstates_out(tstates_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int to_signed16(input int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  // expected model built from integer arithmetic
  function automatic void model(input bit add, input int a, input int b, input int c,
                                output int res, output int flg);
    int full, lowv, sr;
    bit cf, hf, vf, nf;
    if (add) begin
      full = a + b + c;
      lowv = (a & 'hFFF) + (b & 'hFFF) + c;
      sr   = to_signed16(a) + to_signed16(b) + c;
      cf = full > 'hFFFF; hf = lowv > 'hFFF; nf = 0;
    end else begin
      full = a - b - c;
      lowv = (a & 'hFFF) - (b & 'hFFF) - c;
      sr   = to_signed16(a) - to_signed16(b) - c;
      cf = full < 0; hf = lowv < 0; nf = 1;
    end
    vf  = (sr > 32767) || (sr < -32768);
    res = full & 'hFFFF;
    flg = (((res >> 15) & 1) << 7) | ((res == 0) << 6) | (((res >> 13) & 1) << 5) |
          (hf << 4) | (((res >> 11) & 1) << 3) | (vf << 2) | (nf << 1) | cf;
  endfunction

  // drive at a falling edge, sample at the next falling edge
  task automatic run_op(input bit [1:0] sel, input bit add, input bit [15:0] a,
                        input bit [15:0] p0, input bit [15:0] p1, input bit [15:0] sp,
                        input bit cin);
    int b, er, ef;
    acc_in = a; pair0_in = p0; pair1_in = p1; stack_in = sp; carry_in = cin;
    opcode = {2'b01, sel, add, 3'b010};
    strobe = 1'b1;
    case (sel)
      2'd0: b = p0;
      2'd1: b = p1;
      2'd2: b = a;
      default: b = sp;
    endcase
    model(add, int'(a), b, int'(cin), er, ef);
    @(negedge clk);
    strobe = 1'b0;
    check(add ? "R1 add result" : "R2 sub result", acc_out, er);
    check("R3/R4/R5/R6/R7 flags", flags_out, ef);
    check("R8 pointer", ptr_out, (int'(a) + 1) & 'hFFFF);
    check("R9 valid pulse", res_valid, 1);
    check("R10 cycle cost", tstates_out, 15);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hold_acc, hold_flg, hold_ptr;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset valid", res_valid, 0);
    check("R11 reset acc", acc_out, 0);
    check("R11 reset flags", flags_out, 0);
    check("R11 reset ptr", ptr_out, 0);
    check("R11 reset cost", tstates_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", acc_out | flags_out | ptr_out | tstates_out, 0);

    // directed corners: full ripple of incoming carry (R1, R6, R5, R4)
    run_op(2'd0, 1'b1, 16'hFFFF, 16'h0000, 16'h1111, 16'h2222, 1'b1);
    // R7 positive overflow through carry-in only
    run_op(2'd1, 1'b1, 16'h7FFF, 16'h1234, 16'h0000, 16'h0, 1'b1);
    // R2 borrow ripple 0 - 0 - 1
    run_op(2'd3, 1'b0, 16'h0000, 16'h5555, 16'h6666, 16'h0000, 1'b1);
    // R7 subtract overflow 8000 - 1
    run_op(2'd0, 1'b0, 16'h8000, 16'h0001, 16'h0, 16'h0, 1'b0);
    // R3 self operand: 4000 + 4000 overflows
    run_op(2'd2, 1'b1, 16'h4000, 16'h0001, 16'h0002, 16'h0003, 1'b0);
    // R3 self subtract with carry: x - x - 1 = FFFF
    run_op(2'd2, 1'b0, 16'h1234, 16'h0, 16'h0, 16'h0, 1'b1);
    // R8 pointer wrap, stack operand
    run_op(2'd3, 1'b1, 16'hFFFF, 16'h0, 16'h0, 16'h0FFF, 1'b0);
    // R6 half carry only at bit 11
    run_op(2'd1, 1'b1, 16'h0FFF, 16'h0, 16'h0001, 16'h0, 1'b0);

    // R9 back-to-back strobes: second run starts right after the first sample
    run_op(2'd0, 1'b1, 16'h1000, 16'h0234, 16'h0, 16'h0, 1'b0);
    run_op(2'd1, 1'b0, 16'h2000, 16'h0, 16'h0FFF, 16'h0, 1'b0);

    // R9 hold: change every input without a strobe
    hold_acc = acc_out; hold_flg = flags_out; hold_ptr = ptr_out;
    acc_in = 16'hDEAD; pair0_in = 16'hBEEF; pair1_in = 16'hCAFE; stack_in = 16'hF00D;
    carry_in = 1'b1; opcode = 8'h7A;
    repeat (3) @(negedge clk);
    check("R9 no pulse without strobe", res_valid, 0);
    check("R9 acc held", acc_out, hold_acc);
    check("R9 flags held", flags_out, hold_flg);
    check("R9 ptr held", ptr_out, hold_ptr);

    // constrained random mix over all modes and operands
    for (int i = 0; i < 400; i++) begin
      bit [1:0] sel;
      bit add, cin;
      bit [15:0] a;
      sel = 2'($urandom_range(0, 3));
      add = 1'($urandom_range(0, 1));
      cin = 1'($urandom_range(0, 1));
      a = (i % 7 == 0) ? 16'h8000 : 16'($urandom);
      run_op(sel, add, a, 16'($urandom), 16'($urandom), 16'($urandom), cin);
      if (i % 5 == 0) @(negedge clk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule